// File: doc/BRIEF.md
# Time-Shared Complex Twiddle Multiplier

This unit sits behind the butterfly adder of a single-path radix-2 pipelined FFT stage. Each cycle it receives two real words: the sum half and the difference half of a butterfly. The real components of a butterfly arrive in one cycle and the imaginary components in the next. The sum half needs no rotation, so it is only delayed by one register. The difference half is multiplied by the twiddle factor of its butterfly. A full complex product is normally built from four real multipliers. Here it is built from two real multipliers and one real adder/subtractor, reused on alternate cycles. Two product registers and a set of through/cross multiplexers hold the partial products between those cycles.

The words leave the unit in the order they arrived, each one cycle after it entered. The output can therefore feed the commutator of the next stage with no reordering. The twiddle is looked up from a small table that is filled when the design is elaborated. The stage number and the butterfly index select the entry. Products are scaled back to the input width by discarding the fractional bits, which rounds toward minus infinity. Results beyond the input width wrap in two's complement.

Top module: `tshare_twiddle_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0.
- R2: A word accepted with `in_valid`=1 appears on `out_sum` exactly one cycle later. In that same cycle `out_valid`=1 and `out_phase` equals the accepted `in_phase`.
- R3: For a butterfly with real difference a (phase 0), then imaginary difference b (phase 1), and twiddle (c, d): in the cycle where `out_phase`=0, `out_prod` is floor((c·a − d·b)/2^FRAC), taken to DW bits. This is allowed to differ by at most 1 LSB.
- R4: In the next cycle (`out_phase`=1), `out_prod` is floor((d·a + c·b)/2^FRAC), taken to DW bits, within 1 LSB.
- R5: The twiddle for stage value s (`tw_stage` = t−1) and index k has exponent e = (k·2^s) mod N. Its value is c = round(cos(2πe/N)·2^FRAC) and d = round(−sin(2πe/N)·2^FRAC), with ties rounded away from zero.
- R6: A phase-1 word must follow its phase-0 word in the very next cycle. Both words must carry the same `tw_stage` and `tw_index`. Pairs may follow one another with no gap, and every output stays correct.
- R7: An idle cycle (`in_valid`=0) gives `out_valid`=0 one cycle later. The pair results that come after it are not disturbed.
- R8: With `tw_index`=0 the twiddle is exactly 1, so the output difference words equal a and then b.
- R9: With exponent N/4 the twiddle is exactly −j, so the output difference words equal b and then −a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input word pair is present |
| in_phase | input | 1 | 0 = real components, 1 = imaginary components |
| in_sum | input | DW | Sum half of the butterfly, signed |
| in_diff | input | DW | Difference half of the butterfly, signed |
| tw_stage | input | STW | Stage number minus one |
| tw_index | input | LOG2N-1 | Butterfly index k within the stage |
| out_valid | output | 1 | An output word pair is present |
| out_phase | output | 1 | Phase of the output words |
| out_sum | output | DW | Delayed sum half |
| out_prod | output | DW | Difference half after twiddle rotation |

## Verification
The hardest case to reach from the ports is the imaginary result: it is the sum of one product stored two cycles earlier and one stored one cycle earlier. An error there only shows up when the two product registers and the adder's add/subtract mode are used in the right sequence. The stimulus therefore sends long runs of back-to-back pairs over every stage and index, interleaved with idle cycles. The bench also uses the exact twiddles 1 and −j, where any error in swap order or sign turns into a wrong or negated copy of an input word.

// File: rtl/twmul_pkg.sv
package twmul_pkg;

    typedef enum logic {
        PH_RE = 1'b0,
        PH_IM = 1'b1
    } phase_e;

    // Steering of the product registers and the adder
    typedef enum logic {
        MX_CROSS = 1'b0,   // cross routing, adder subtracts
        MX_THRU  = 1'b1    // straight routing, adder adds
    } route_e;

    localparam real TW_PI = 3.14159265358979323846;

    function automatic real tw_angle(input int e, input int n);
        real th;
        th = 2.0 * TW_PI * real'(e) / real'(n);
        if (th > TW_PI) th = th - 2.0 * TW_PI;
        return th;
    endfunction

    function automatic real tw_cos(input int e, input int n);
        real x, term, acc;
        x    = tw_angle(e, n);
        term = 1.0;
        acc  = 1.0;
        for (int i = 1; i < 24; i++) begin
            term = -term * x * x / (real'(2 * i - 1) * real'(2 * i));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic real tw_sin(input int e, input int n);
        real x, term, acc;
        x    = tw_angle(e, n);
        term = x;
        acc  = x;
        for (int i = 1; i < 24; i++) begin
            term = -term * x * x / (real'(2 * i) * real'(2 * i + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Scale by 2^frac and round half away from zero
    function automatic longint tw_quant(input real v, input int frac);
        real s;
        s = v * real'(longint'(1) << frac);
        if (s >= 0.0) return longint'($rtoi(s + 0.5));
        else          return -longint'($rtoi(-s + 0.5));
    endfunction

endpackage

// File: rtl/twmul_rom.sv
module twmul_rom
    import twmul_pkg::*;
#(
    parameter int LOG2N = 4,
    parameter int FRAC  = 14,
    parameter int TWW   = FRAC + 2,
    parameter int STW   = 2
) (
    input  logic [STW-1:0]          stage,
    input  logic [LOG2N-2:0]        index,
    output logic signed [TWW-1:0]   tw_c,
    output logic signed [TWW-1:0]   tw_d
);
    localparam int N = 1 << LOG2N;

    logic signed [TWW-1:0] cos_tab [N];
    logic signed [TWW-1:0] nsin_tab [N];

    for (genvar e = 0; e < N; e++) begin : g_ent
        localparam longint CV = tw_quant(tw_cos(e, N), FRAC);
        localparam longint SV = tw_quant(-tw_sin(e, N), FRAC);
        assign cos_tab[e]  = TWW'(CV);
        assign nsin_tab[e] = TWW'(SV);
    end

    logic [LOG2N-1:0] idx_w;
    logic [LOG2N-1:0] expo;

    always_comb begin
        idx_w = {1'b0, index};
        expo  = idx_w << stage;
        tw_c  = cos_tab[expo];
        tw_d  = nsin_tab[expo];
    end

endmodule

// File: rtl/twmul_sum_delay.sv
module twmul_sum_delay
    import twmul_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  phase_e               in_phase,
    input  logic signed [DW-1:0] in_sum,
    output logic                 out_valid,
    output phase_e               out_phase,
    output logic signed [DW-1:0] out_sum
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_phase <= PH_RE;
            out_sum   <= '0;
        end else begin
            out_valid <= in_valid;
            out_phase <= in_phase;
            out_sum   <= in_sum;
        end
    end

endmodule

// File: rtl/twmul_core.sv
module twmul_core
    import twmul_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 14,
    parameter int TWW  = FRAC + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  phase_e                in_phase,
    input  logic signed [DW-1:0]  diff,
    input  logic signed [TWW-1:0] tw_c,
    input  logic signed [TWW-1:0] tw_d,
    output logic signed [DW-1:0]  prod
);
    localparam int PW = DW + TWW;
    localparam int AW = PW + 1;

    route_e               route;
    logic signed [PW-1:0] p_c, p_d;
    logic signed [PW-1:0] hold_a, hold_b;   // the two product registers
    logic signed [PW-1:0] add_rhs;
    logic signed [AW-1:0] acc;

    // Cross only while an imaginary word is present
    always_comb begin
        route = (in_valid && in_phase == PH_IM) ? MX_CROSS : MX_THRU;
    end

    always_comb begin
        p_c = PW'(diff) * PW'(tw_c);
        p_d = PW'(diff) * PW'(tw_d);
    end

    // Adder right operand: stored product when straight, live product when crossed
    always_comb begin
        add_rhs = (route == MX_THRU) ? hold_a : p_d;
        if (route == MX_THRU)
            acc = AW'(hold_b) + AW'(add_rhs);
        else
            acc = AW'(hold_b) - AW'(add_rhs);
        prod = DW'(acc >>> FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_a <= '0;
            hold_b <= '0;
        end else if (route == MX_THRU) begin
            hold_a <= p_d;
            hold_b <= p_c;
        end else begin
            hold_a <= p_c;
            hold_b <= hold_a;
        end
    end

endmodule

// File: rtl/tshare_twiddle_mul.sv
module tshare_twiddle_mul
    import twmul_pkg::*;
#(
    parameter int LOG2N = 4,
    parameter int DW    = 16,
    parameter int FRAC  = 14,
    parameter int STW   = (LOG2N > 2) ? $clog2(LOG2N - 1) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_phase,
    input  logic signed [DW-1:0]   in_sum,
    input  logic signed [DW-1:0]   in_diff,
    input  logic [STW-1:0]         tw_stage,
    input  logic [LOG2N-2:0]       tw_index,
    output logic                   out_valid,
    output logic                   out_phase,
    output logic signed [DW-1:0]   out_sum,
    output logic signed [DW-1:0]   out_prod
);
    localparam int TWW = FRAC + 2;

    phase_e                 ph_in;
    phase_e                 ph_out;
    logic signed [TWW-1:0]  tw_c, tw_d;

    assign ph_in     = phase_e'(in_phase);
    assign out_phase = logic'(ph_out);

    twmul_rom #(
        .LOG2N(LOG2N), .FRAC(FRAC), .TWW(TWW), .STW(STW)
    ) u_rom (
        .stage (tw_stage),
        .index (tw_index),
        .tw_c  (tw_c),
        .tw_d  (tw_d)
    );

    twmul_core #(
        .DW(DW), .FRAC(FRAC), .TWW(TWW)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_phase (ph_in),
        .diff     (in_diff),
        .tw_c     (tw_c),
        .tw_d     (tw_d),
        .prod     (out_prod)
    );

    twmul_sum_delay #(
        .DW(DW)
    ) u_dly (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_phase  (ph_in),
        .in_sum    (in_sum),
        .out_valid (out_valid),
        .out_phase (ph_out),
        .out_sum   (out_sum)
    );

endmodule

// File: rtl/twmul_checker.sv
module twmul_checker #(
    parameter int LOG2N = 4,
    parameter int DW    = 16,
    parameter int STW   = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_phase,
    input logic signed [DW-1:0] in_sum,
    input logic signed [DW-1:0] in_diff,
    input logic [STW-1:0]       tw_stage,
    input logic [LOG2N-2:0]     tw_index,
    input logic                 out_valid,
    input logic                 out_phase,
    input logic signed [DW-1:0] out_sum,
    input logic signed [DW-1:0] out_prod
);
    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_sum_delay_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid && out_sum == $past(in_sum)
                     && out_phase == $past(in_phase));

    assert_pair_order_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_phase |=> in_valid && in_phase
                                  && $stable(tw_index) && $stable(tw_stage));

    assert_unit_real_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_phase && tw_index == '0 |-> out_prod == $past(in_diff));

    assert_unit_imag_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_phase && $past(in_valid) && $past(tw_index) == '0
        |-> out_prod == $past(in_diff));

endmodule

bind tshare_twiddle_mul twmul_checker #(
    .LOG2N(LOG2N), .DW(DW), .STW(STW)
) u_chk (.*);

// File: tb/tb_tshare_twiddle_mul.sv
`timescale 1ns/1ps
module tb_tshare_twiddle_mul;
    localparam int LOG2N = 4;
    localparam int N     = 1 << LOG2N;
    localparam int DW    = 16;
    localparam int FRAC  = 14;
    localparam int STW   = 2;
    localparam real PI   = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_phase = 1'b0;
    logic signed [DW-1:0] in_sum = '0;
    logic signed [DW-1:0] in_diff = '0;
    logic [STW-1:0]       tw_stage = '0;
    logic [LOG2N-2:0]     tw_index = '0;
    logic                 out_valid, out_phase;
    logic signed [DW-1:0] out_sum, out_prod;

    tshare_twiddle_mul #(.LOG2N(LOG2N), .DW(DW), .FRAC(FRAC)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
        .in_sum(in_sum), .in_diff(in_diff), .tw_stage(tw_stage),
        .tw_index(tw_index), .out_valid(out_valid), .out_phase(out_phase),
        .out_sum(out_sum), .out_prod(out_prod)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int    q_stamp[$];
    bit    q_v[$];
    bit    q_ph[$];
    int    q_sum[$];
    int    q_prod[$];
    string q_tag[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint rnd(input real v);
        if (v >= 0.0) return longint'($rtoi(v + 0.5));
        else          return -longint'($rtoi(-v + 0.5));
    endfunction

    function automatic int wrap(input longint v);
        logic signed [DW-1:0] t;
        t = DW'(v);
        return int'(t);
    endfunction

    task automatic push(input bit v, input bit ph, input int s, input int p, input string tag);
        q_stamp.push_back(cyc + 1);
        q_v.push_back(v);
        q_ph.push_back(ph);
        q_sum.push_back(s);
        q_prod.push_back(p);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(posedge clk); #1;
        in_valid = 1'b0;
        push(1'b0, 1'b0, 0, 0, tag);
    endtask

    // R5: twiddle model; R3/R4: truncated complex product
    task automatic send_pair(input int st, input int k, input int sr, input int si,
                             input int a, input int b, input string tag);
        int e;
        real th;
        longint c, d, re, im;
        e  = (k << st) % N;
        th = 2.0 * PI * real'(e) / real'(N);
        c  = rnd($cos(th) * real'(1 << FRAC));
        d  = rnd(-$sin(th) * real'(1 << FRAC));
        re = (c * longint'(a) - d * longint'(b)) >>> FRAC;
        im = (d * longint'(a) + c * longint'(b)) >>> FRAC;
        @(posedge clk); #1;
        in_valid = 1'b1; in_phase = 1'b0; in_sum = DW'(sr); in_diff = DW'(a);
        tw_stage = STW'(st); tw_index = (LOG2N-1)'(k);
        push(1'b1, 1'b0, wrap(sr), wrap(re), {tag, " R3"});
        @(posedge clk); #1;
        in_phase = 1'b1; in_sum = DW'(si); in_diff = DW'(b);
        push(1'b1, 1'b1, wrap(si), wrap(im), {tag, " R4"});
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && q_stamp.size() > 0 && q_stamp[0] == cyc) begin
            bit v, ph; int s, p; string tag;
            int dlt;
            void'(q_stamp.pop_front());
            v = q_v.pop_front(); ph = q_ph.pop_front();
            s = q_sum.pop_front(); p = q_prod.pop_front(); tag = q_tag.pop_front();
            check(out_valid == v, {tag, " valid R2/R7"}, int'(out_valid), int'(v));
            if (v) begin
                check(out_phase == ph, {tag, " phase R2"}, int'(out_phase), int'(ph));
                check(int'(out_sum) == s, {tag, " sum R2"}, int'(out_sum), s);
                dlt = wrap(longint'(int'(out_prod)) - longint'(p));
                check(dlt >= -1 && dlt <= 1, {tag, " product"}, int'(out_prod), p);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "reset R1", int'(out_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "after reset R1", int'(out_valid), 0);

        // R8: unit twiddle returns a, b
        send_pair(0, 0, 11, -7, 1234, -4321, "unit R8");
        send_pair(2, 0, 0, 0, -32768, 32767, "unit edge R8");
        // R9: exponent N/4 -> -j, outputs b then -a
        send_pair(0, 4, 5, 6, 1000, 300, "minus_j R9");
        send_pair(1, 2, -5, -6, -2500, 777, "minus_j st1 R9");
        idle("gap R7");
        idle("gap R7");
        // R5/R6: every stage and index, back to back
        for (int st = 0; st < LOG2N - 1; st++) begin
            for (int k = 0; k < N / 2; k++) begin
                send_pair(st, k, $urandom_range(0, 65535) - 32768,
                          $urandom_range(0, 65535) - 32768,
                          $urandom_range(0, 65535) - 32768,
                          $urandom_range(0, 65535) - 32768, "sweep R5 R6");
            end
        end
        // R7: pairs separated by idle cycles
        for (int i = 0; i < 40; i++) begin
            send_pair(i % 3, (i * 5) % 8, i * 17, -i * 3,
                      $urandom_range(0, 65535) - 32768,
                      $urandom_range(0, 65535) - 32768, "gapped R7");
            if (i % 2 == 0) idle("gap R7");
        end
        // Extremes, wrap on overflow
        send_pair(0, 1, 32767, -32768, -32768, -32768, "extreme R3");
        send_pair(0, 3, -32768, 32767, 32767, -32768, "extreme R4");
        idle("flush R7");
        idle("flush R7");
        repeat (3) @(posedge clk);
        check(q_stamp.size() == 0, "scoreboard drained R2", q_stamp.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #200000;
                n_run++; n_fail++;
                $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule